// File: doc/BRIEF.md
# Decay-Aware Shared Cache Tag and Replacement Controller

This block holds the tags and the replacement state of a set-associative cache that several hardware threads share. Each request carries an address and a thread number. The block answers one cycle later with hit or miss, the way that was used, and the reason that way was chosen. A miss allocates the line in the chosen way at once. The data array lives outside the block.

Every line records the thread that filled it and a small saturating age counter. The counter measures time in allocations, not in clock cycles: each fill anywhere in the cache adds one to every other line's counter. A line whose age has reached its owner thread's programmable interval is treated as stale. A stale line stays valid and still hits. It is only preferred when a victim has to be chosen. This steers the replacement choice without fixing a partition between threads. When no line in the set is stale, a base policy chooses the victim: true LRU or pseudo-random, selected by a pin.

Top module: `dcy_cache_ctrl`

## Requirements
- R1: A request is answered exactly one cycle later with `resp_valid` high. The response reports a hit, with the matching way, when a valid line of the indexed set holds the request's tag. `req_addr` is {tag, set index}, and the set index is the low `$clog2(NSETS)` bits.
- R2: On a miss, the lowest-numbered invalid way of the set is filled first (`resp_kind` = 1), even when stale lines exist.
- R3: A line's age is cleared when the line is hit or filled. Every fill adds one to the age of every other line in the cache, saturating at 15. A line is stale when its age is greater than or equal to its owner's interval.
- R4: On a miss with no invalid way, the lowest-numbered stale way is the victim (`resp_kind` = 2).
- R5: A hit on a stale line is reported as a normal hit with `resp_hit_decayed` high, and the hit makes the line fresh again.
- R6: An interval of 0 means the thread's lines never become stale, whatever their age.
- R7: With `policy_rand` low and no invalid or stale way, the least recently hit-or-filled way is the victim (`resp_kind` = 3).
- R8: With `policy_rand` high and no invalid or stale way, a way taken from a 16-bit LFSR is replaced (`resp_kind` = 3), and the new line then hits.
- R9: An interval write takes effect for requests in later cycles. A request in the same cycle as the write uses the old value.
- R10: After reset no response is pending, all lines are invalid and all intervals are 0. `resp_kind` encodes 0 = hit, 1 = invalid fill, 2 = stale victim, 3 = base-policy victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_rand | input | 1 | Base policy: 0 = LRU, 1 = LFSR |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | TAG_W+log2(NSETS) | {tag, set index} |
| req_tid | input | log2(NTHREADS) | Requesting thread |
| cfg_we | input | 1 | Interval register write enable |
| cfg_tid | input | log2(NTHREADS) | Thread whose interval is written |
| cfg_interval | input | CNT_W | New interval in allocations (0 = never stale) |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | log2(NWAYS) | Way hit or filled |
| resp_kind | output | 2 | Reason for the way choice |
| resp_hit_decayed | output | 1 | The hit landed on a stale line |

## Verification
An interval-register write and a lookup whose victim choice depends on that interval can fall in the same cycle. The bench builds a full set whose LRU way is also the only candidate for staleness under the new interval. It then issues the write and a missing lookup on one clock edge. The old interval must win, which gives a base-policy fill of that way. The next miss must see the new interval and take the stale way instead.

// File: rtl/dcy_pkg.sv
package dcy_pkg;
  typedef enum logic [1:0] {
    K_HIT  = 2'd0,
    K_INV  = 2'd1,
    K_DEC  = 2'd2,
    K_BASE = 2'd3
  } kind_e;
endpackage

// File: rtl/dcy_lfsr.sv
module dcy_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [15:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  end

  assign rnd = q[OUT_W-1:0];

  // R8
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst) q != 16'd0);
endmodule

// File: rtl/dcy_lru.sv
module dcy_lru #(
  parameter int NSETS = 16,
  parameter int NWAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NSETS)-1:0] rd_set,
  input  logic                     upd_en,
  input  logic [$clog2(NSETS)-1:0] upd_set,
  input  logic [$clog2(NWAYS)-1:0] upd_way,
  output logic [$clog2(NWAYS)-1:0] lru_way
);
  localparam int SET_W = $clog2(NSETS);
  localparam int WAY_W = $clog2(NWAYS);

  logic [WAY_W-1:0] rank_q [NSETS][NWAYS];
  logic [NWAYS-1:0] oldest_vec;

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      oldest_vec[w] = (rank_q[rd_set][w] == WAY_W'(NWAYS - 1));
      if (oldest_vec[w]) lru_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < NWAYS; w++)
          rank_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < NWAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          rank_q[upd_set][w] <= '0;
        else if (rank_q[upd_set][w] < rank_q[upd_set][upd_way])
          rank_q[upd_set][w] <= rank_q[upd_set][w] + 1'b1;
      end
    end
  end

  logic             last_en;
  logic [SET_W-1:0] last_set;
  logic [WAY_W-1:0] last_way;
  always_ff @(posedge clk) begin
    if (rst) begin
      last_en  <= 1'b0;
      last_set <= '0;
      last_way <= '0;
    end else begin
      last_en  <= upd_en;
      last_set <= upd_set;
      last_way <= upd_way;
    end
  end

  // R7
  touched_newest_chk: assert property (@(posedge clk) disable iff (rst)
    last_en |-> rank_q[last_set][last_way] == '0);
  // R7
  single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/dcy_victim_sel.sv
module dcy_victim_sel
  import dcy_pkg::*;
#(
  parameter int NWAYS = 4
) (
  input  logic [NWAYS-1:0]         valid_vec,
  input  logic [NWAYS-1:0]         dec_vec,
  input  logic [$clog2(NWAYS)-1:0] base_way,
  output logic [$clog2(NWAYS)-1:0] vict_way,
  output kind_e                    vict_kind
);
  localparam int WAY_W = $clog2(NWAYS);

  logic [WAY_W-1:0] inv_way, dec_way;
  logic             any_inv, any_dec;

  always_comb begin
    inv_way = '0;
    dec_way = '0;
    any_inv = 1'b0;
    any_dec = 1'b0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
      if (dec_vec[w]) begin
        dec_way = WAY_W'(w);
        any_dec = 1'b1;
      end
    end
    if (any_inv) begin
      vict_way  = inv_way;
      vict_kind = K_INV;
    end else if (any_dec) begin
      vict_way  = dec_way;
      vict_kind = K_DEC;
    end else begin
      vict_way  = base_way;
      vict_kind = K_BASE;
    end
  end
endmodule

// File: rtl/dcy_cache_ctrl.sv
module dcy_cache_ctrl
  import dcy_pkg::*;
#(
  parameter int          NSETS     = 16,
  parameter int          NWAYS     = 4,
  parameter int          NTHREADS  = 4,
  parameter int          TAG_W     = 8,
  parameter int          CNT_W     = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              policy_rand,
  input  logic                              req_valid,
  input  logic [TAG_W+$clog2(NSETS)-1:0]    req_addr,
  input  logic [$clog2(NTHREADS)-1:0]       req_tid,
  input  logic                              cfg_we,
  input  logic [$clog2(NTHREADS)-1:0]       cfg_tid,
  input  logic [CNT_W-1:0]                  cfg_interval,
  output logic                              resp_valid,
  output logic                              resp_hit,
  output logic [$clog2(NWAYS)-1:0]          resp_way,
  output logic [1:0]                        resp_kind,
  output logic                              resp_hit_decayed
);
  localparam int SET_W  = $clog2(NSETS);
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int TID_W  = $clog2(NTHREADS);
  localparam int ADDR_W = TAG_W + SET_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  assign set_idx = req_addr[SET_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:SET_W];

  logic             valid_q [NSETS][NWAYS];
  logic [TID_W-1:0] own_q   [NSETS][NWAYS];
  logic [CNT_W-1:0] cnt_q   [NSETS][NWAYS];
  logic [TAG_W-1:0] tag_q   [NSETS][NWAYS];
  logic [CNT_W-1:0] intv_q  [NTHREADS];

  logic [NWAYS-1:0] val_vec, hit_vec, dec_vec;

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    logic [CNT_W-1:0] iv;
    always_comb begin
      iv         = intv_q[own_q[set_idx][g]];
      val_vec[g] = valid_q[set_idx][g];
      hit_vec[g] = val_vec[g] && (tag_q[set_idx][g] == req_tag);
      dec_vec[g] = val_vec[g] && (iv != '0) && (cnt_q[set_idx][g] >= iv);
    end
  end

  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  always_comb begin
    any_hit = 1'b0;
    hit_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  logic [WAY_W-1:0] lru_way, rnd_way, base_way, vict_way, upd_way;
  kind_e            vict_kind;

  dcy_lru #(.NSETS(NSETS), .NWAYS(NWAYS)) u_lru (
    .clk(clk), .rst(rst), .rd_set(set_idx), .upd_en(req_valid),
    .upd_set(set_idx), .upd_way(upd_way), .lru_way(lru_way)
  );

  dcy_lfsr #(.SEED(LFSR_SEED), .OUT_W(WAY_W)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd_way)
  );

  assign base_way = policy_rand ? rnd_way : lru_way;

  dcy_victim_sel #(.NWAYS(NWAYS)) u_vsel (
    .valid_vec(val_vec), .dec_vec(dec_vec), .base_way(base_way),
    .vict_way(vict_way), .vict_kind(vict_kind)
  );

  assign upd_way = any_hit ? hit_way : vict_way;

  // line state: validity, owner, age
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < NWAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          own_q[s][w]   <= '0;
          cnt_q[s][w]   <= '0;
        end
    end else if (req_valid) begin
      if (any_hit) begin
        cnt_q[set_idx][hit_way] <= '0;
      end else begin
        for (int s = 0; s < NSETS; s++)
          for (int w = 0; w < NWAYS; w++) begin
            if (SET_W'(s) == set_idx && WAY_W'(w) == vict_way) begin
              cnt_q[s][w]   <= '0;
              valid_q[s][w] <= 1'b1;
              own_q[s][w]   <= req_tid;
            end else if (cnt_q[s][w] != CNT_MAX) begin
              cnt_q[s][w] <= cnt_q[s][w] + 1'b1;
            end
          end
      end
    end
  end

  // tag store, no reset
  always_ff @(posedge clk) begin
    if (req_valid && !any_hit) tag_q[set_idx][vict_way] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTHREADS; t++) intv_q[t] <= '0;
    end else if (cfg_we) begin
      intv_q[cfg_tid] <= cfg_interval;
    end
  end

  logic [SET_W-1:0] rset_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid       <= 1'b0;
      resp_hit         <= 1'b0;
      resp_way         <= '0;
      resp_kind        <= K_HIT;
      resp_hit_decayed <= 1'b0;
      rset_q           <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit         <= any_hit;
        resp_way         <= upd_way;
        resp_kind        <= any_hit ? K_HIT : vict_kind;
        resp_hit_decayed <= any_hit && dec_vec[hit_way];
        rset_q           <= set_idx;
      end
    end
  end

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  // R5
  decayed_hit_is_hit_chk: assert property (@(posedge clk) disable iff (rst)
    resp_hit_decayed |-> resp_hit);
  // R3
  fill_clears_age_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (cnt_q[rset_q][resp_way] == '0 && valid_q[rset_q][resp_way]));
  // R2
  inv_fill_target_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_hit && vict_kind == K_INV) |-> !val_vec[vict_way]);
  // R4
  dec_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_hit && vict_kind == K_DEC) |-> (dec_vec[vict_way] && (&val_vec)));
endmodule

// File: tb/tb_dcy_cache_ctrl.sv
module tb_dcy_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] KH = 2'd0, KI = 2'd1, KD = 2'd2, KB = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       policy_rand = 1'b0;
  logic       req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_tid = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_tid = '0;
  logic [3:0] cfg_interval = '0;
  logic       resp_valid, resp_hit, resp_hit_decayed;
  logic [1:0] resp_way, resp_kind;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dcy_cache_ctrl dut (
    .clk(clk), .rst(rst), .policy_rand(policy_rand), .req_valid(req_valid),
    .req_addr(req_addr), .req_tid(req_tid), .cfg_we(cfg_we), .cfg_tid(cfg_tid),
    .cfg_interval(cfg_interval), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .resp_kind(resp_kind), .resp_hit_decayed(resp_hit_decayed)
  );

  typedef struct {
    logic       hit;
    logic [1:0] way;
    logic [1:0] kind;
    logic       hdec;
    bit         chk_way;
    string      rq;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic lookup(input int tag, input int set, input int tid,
                        input bit eh, input int ew, input logic [1:0] ek,
                        input bit ed, input bit cw, input string rq,
                        input bit cfg = 0, input int ct = 0, input int cv = 0);
    exp_t e;
    @(negedge clk);
    req_valid    = 1'b1;
    req_addr     = {8'(tag), 4'(set)};
    req_tid      = 2'(tid);
    cfg_we       = cfg;
    cfg_tid      = 2'(ct);
    cfg_interval = 4'(cv);
    e.hit = eh; e.way = 2'(ew); e.kind = ek; e.hdec = ed; e.chk_way = cw; e.rq = rq;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    cfg_we    = 1'b0;
  endtask

  task automatic set_interval(input int t, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tid = 2'(t); cfg_interval = 4'(v);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response act hit=%0d way=%0d exp none", resp_hit, resp_way);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (resp_hit !== e.hit || resp_kind !== e.kind || resp_hit_decayed !== e.hdec ||
            (e.chk_way && resp_way !== e.way)) begin
          fails++;
          $display("FAIL %s: act hit=%0d way=%0d kind=%0d hdec=%0d exp hit=%0d way=%0d kind=%0d hdec=%0d",
                   e.rq, resp_hit, resp_way, resp_kind, resp_hit_decayed,
                   e.hit, e.way, e.kind, e.hdec);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: reset resp_valid act %0d exp 0", resp_valid);
    end

    // set 0, LRU base, thread 0 interval 0 after reset (R10, R2, R1, R7)
    lookup(1, 0, 0, 0, 0, KI, 0, 1, "R10");
    lookup(2, 0, 0, 0, 1, KI, 0, 1, "R2");
    lookup(3, 0, 0, 0, 2, KI, 0, 1, "R2");
    lookup(4, 0, 0, 0, 3, KI, 0, 1, "R2");
    lookup(1, 0, 0, 1, 0, KH, 0, 1, "R1");
    set_interval(1, 2);
    lookup(5, 0, 0, 0, 1, KB, 0, 1, "R7");

    // set 1: thread 1 interval 2 (R4, R5, R6)
    lookup(10, 1, 1, 0, 0, KI, 0, 1, "R2");
    lookup(11, 1, 1, 0, 1, KI, 0, 1, "R2");
    lookup(12, 1, 0, 0, 2, KI, 0, 1, "R2");
    lookup(13, 1, 0, 0, 3, KI, 0, 1, "R2");
    lookup(14, 1, 0, 0, 0, KD, 0, 1, "R4");
    lookup(11, 1, 1, 1, 1, KH, 1, 1, "R5");
    lookup(11, 1, 1, 1, 1, KH, 0, 1, "R5");
    lookup(15, 1, 0, 0, 2, KB, 0, 1, "R6");

    // set 2: thread 2 interval 1 (R2 over stale, R4, R3 equality)
    set_interval(2, 1);
    lookup(20, 2, 2, 0, 0, KI, 0, 1, "R2");
    lookup(21, 2, 2, 0, 1, KI, 0, 1, "R2");
    lookup(22, 2, 2, 0, 2, KI, 0, 1, "R2");
    lookup(23, 2, 2, 0, 3, KI, 0, 1, "R2");
    lookup(24, 2, 2, 0, 0, KD, 0, 1, "R4");
    lookup(23, 2, 2, 1, 3, KH, 1, 1, "R3");
    lookup(23, 2, 2, 1, 3, KH, 0, 1, "R5");

    // set 5: interval write in the same cycle as a miss (R9)
    lookup(50, 5, 3, 0, 0, KI, 0, 1, "R2");
    lookup(51, 5, 3, 0, 1, KI, 0, 1, "R2");
    lookup(52, 5, 3, 0, 2, KI, 0, 1, "R2");
    lookup(53, 5, 3, 0, 3, KI, 0, 1, "R2");
    lookup(53, 5, 3, 1, 3, KH, 0, 1, "R1");
    lookup(50, 5, 3, 1, 0, KH, 0, 1, "R1");
    lookup(54, 5, 3, 0, 1, KB, 0, 1, "R9", 1, 3, 2);
    lookup(55, 5, 3, 0, 2, KD, 0, 1, "R9");

    // saturation: set 6 line ages through 23 fills (R3), set 7 LRU cycling (R7)
    set_interval(1, 15);
    lookup(60, 6, 1, 0, 0, KI, 0, 1, "R2");
    for (int i = 0; i < 20; i++)
      lookup(70 + i, 7, 0, 0, i % 4, (i < 4) ? KI : KB, 0, 1, "R7");
    lookup(61, 6, 1, 0, 1, KI, 0, 1, "R2");
    lookup(62, 6, 1, 0, 2, KI, 0, 1, "R2");
    lookup(63, 6, 1, 0, 3, KI, 0, 1, "R2");
    lookup(64, 6, 1, 0, 0, KD, 0, 1, "R3");

    // random base policy (R8)
    @(negedge clk);
    policy_rand = 1'b1;
    lookup(30, 3, 0, 0, 0, KI, 0, 1, "R2");
    lookup(31, 3, 0, 0, 1, KI, 0, 1, "R2");
    lookup(32, 3, 0, 0, 2, KI, 0, 1, "R2");
    lookup(33, 3, 0, 0, 3, KI, 0, 1, "R2");
    lookup(34, 3, 0, 0, 0, KB, 0, 0, "R8");
    lookup(34, 3, 0, 1, 0, KH, 0, 0, "R8");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: pending responses act %0d exp 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule